// File: doc/BRIEF.md
# Condition-Flag Data-Processing ALU

This block is the arithmetic and logic stage of a 32-bit integer datapath. Each cycle it takes two operands, a 4-bit operation code, the carry produced by an upstream operand shifter, a set-flags request and the current negative, zero, carry and overflow flags. It computes one of sixteen operations and the flag values that follow from it. All outputs pass through a single register stage, so a result appears one clock after its inputs.

Four of the operations are comparisons. They only update flags and never request a register write. When one of them arrives with set-flags clear, the block raises an illegal-operation indication. When the destination is the program counter and set-flags is active, a separate output tells the surrounding logic to restore the saved processor mode. Operand shifting, register writeback and the mode change itself belong to the caller.

Top module: `dp_flag_alu`

## Requirements
- R1: The opcode is decoded as 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, A CMP, B CMN, C ORR, D MOV, E BIC, F MVN. For the bitwise group, `result` is a&b (AND, TST), a^b (EOR, TEQ), a|b (ORR), b (MOV), a&~b (BIC) or ~b (MVN). MOV and MVN do not depend on `op_a`.
- R2: SUB and CMP give a−b, RSB gives b−a, and ADD and CMN give a+b, all modulo 2^32.
- R3: ADC gives a+b+C, SBC gives a−b+C−1 and RSC gives b−a+C−1. C is the incoming carry, `flags_in[1]`.
- R4: Opcodes 8 to B (TST, TEQ, CMP, CMN) drive `result_we` low while `result` still carries the computed value. Every other opcode drives `result_we` high.
- R5: With `set_flags` high, N (`flags_out[3]`) equals result bit 31 and Z (`flags_out[2]`) is 1 exactly when the 32-bit result is zero, for every opcode.
- R6: With `set_flags` high, the bitwise opcodes set C (`flags_out[1]`) to `shift_carry` and pass V (`flags_out[0]`) through from `flags_in[0]`.
- R7: With `set_flags` high, the arithmetic opcodes set C to the adder carry-out, which for subtraction is 1 when no borrow occurs. They set V to 1 when the signed result overflows 32 bits.
- R8: With `set_flags` low, `flags_out` equals `flags_in`.
- R9: `illegal_op` is 1 exactly when the opcode is 8 to B and `set_flags` is low.
- R10: `mode_restore` is 1 exactly when `dest_is_pc` and `set_flags` are both high.
- R11: All outputs are registered, so they reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| shift_carry | input | 1 | Carry-out from the operand shifter |
| opcode | input | 4 | Operation code |
| set_flags | input | 1 | Request to update the flags |
| dest_is_pc | input | 1 | Destination register is the program counter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Computed value |
| result_we | output | 1 | Result should be written back |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| mode_restore | output | 1 | Destination is the program counter with set-flags active |
| illegal_op | output | 1 | Compare opcode issued with set-flags clear |

## Verification
The bench targets the carry convention on subtraction: a subtract with equal operands must set C. A design that used a raw borrow would clear C there and would also invert it on 1−2. It also targets signed overflow at the 0x7FFFFFFF and 0x80000000 edges, where an error in the sign rule shows up as a wrong V. The carry-folding opcodes are driven with the incoming carry both set and clear, which exposes a missing or inverted carry-in as an off-by-one result. Compare opcodes are issued with set-flags on and off, and bitwise opcodes are issued with V set, so a block that writes on a compare, changes flags without a request or clears V would be caught.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int DP_W      = 32;
    localparam int FLAG_W    = 4;

    typedef enum logic [3:0] {
        OP_AND = 4'h0,
        OP_EOR = 4'h1,
        OP_SUB = 4'h2,
        OP_RSB = 4'h3,
        OP_ADD = 4'h4,
        OP_ADC = 4'h5,
        OP_SBC = 4'h6,
        OP_RSC = 4'h7,
        OP_TST = 4'h8,
        OP_TEQ = 4'h9,
        OP_CMP = 4'hA,
        OP_CMN = 4'hB,
        OP_ORR = 4'hC,
        OP_MOV = 4'hD,
        OP_BIC = 4'hE,
        OP_MVN = 4'hF
    } dp_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dp_flags_t;

    // How the shared adder is fed for one opcode
    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_CARRY = 2'd2
    } dp_cin_e;

    typedef struct packed {
        logic    is_logic;
        logic    is_compare;
        logic    swap_ops;
        logic    invert_y;
        dp_cin_e cin_mode;
    } dp_ctrl_t;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
    import dp_alu_pkg::*;
(
    input  logic [3:0] opcode,
    output dp_ctrl_t   ctrl
);

    dp_op_e op;
    assign op = dp_op_e'(opcode);

    always_comb begin
        ctrl            = '0;
        ctrl.is_compare = (opcode[3:2] == 2'b10);
        unique case (op)
            OP_AND, OP_EOR, OP_TST, OP_TEQ,
            OP_ORR, OP_MOV, OP_BIC, OP_MVN: begin
                ctrl.is_logic = 1'b1;
            end
            OP_SUB, OP_CMP: begin
                ctrl.invert_y = 1'b1;
                ctrl.cin_mode = CIN_ONE;
            end
            OP_RSB: begin
                ctrl.swap_ops = 1'b1;
                ctrl.invert_y = 1'b1;
                ctrl.cin_mode = CIN_ONE;
            end
            OP_ADD, OP_CMN: begin
                ctrl.cin_mode = CIN_ZERO;
            end
            OP_ADC: begin
                ctrl.cin_mode = CIN_CARRY;
            end
            OP_SBC: begin
                ctrl.invert_y = 1'b1;
                ctrl.cin_mode = CIN_CARRY;
            end
            OP_RSC: begin
                ctrl.swap_ops = 1'b1;
                ctrl.invert_y = 1'b1;
                ctrl.cin_mode = CIN_CARRY;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/dp_adder.sv
module dp_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] full;

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum  = full[MSB:0];
        cout = full[WIDTH];
        // operands of equal sign producing a result of the other sign
        ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

endmodule

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       opcode,
    output logic [WIDTH-1:0] y
);

    always_comb begin
        unique case (dp_op_e'(opcode))
            OP_AND, OP_TST: y = a & b;
            OP_EOR, OP_TEQ: y = a ^ b;
            OP_ORR:         y = a | b;
            OP_MOV:         y = b;
            OP_BIC:         y = a & ~b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end

endmodule

// File: rtl/dp_flag_gen.sv
module dp_flag_gen
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    input  logic             is_logic,
    input  logic             set_flags,
    input  logic             shift_carry,
    input  logic             add_carry,
    input  logic             add_ovf,
    input  dp_flags_t        cur,
    output dp_flags_t        nxt
);

    always_comb begin
        nxt = cur;
        if (set_flags) begin
            nxt.n = value[WIDTH-1];
            nxt.z = (value == '0);
            if (is_logic) begin
                nxt.c = shift_carry;
            end else begin
                nxt.c = add_carry;
                nxt.v = add_ovf;
            end
        end
    end

endmodule

// File: rtl/dp_flag_alu.sv
module dp_flag_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = DP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic              shift_carry,
    input  logic [3:0]        opcode,
    input  logic              set_flags,
    input  logic              dest_is_pc,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [WIDTH-1:0]  result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags_out,
    output logic              mode_restore,
    output logic              illegal_op
);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             we;
        dp_flags_t        flags;
        logic             restore;
        logic             illegal;
    } stage_t;

    dp_ctrl_t         ctrl;
    dp_flags_t        cur_flags;
    dp_flags_t        nxt_flags;
    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] sel_res;
    stage_t           stage_d;
    stage_t           stage_q;

    assign cur_flags = dp_flags_t'(flags_in);

    dp_decode u_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    // operand steering for the single shared adder
    always_comb begin
        add_x = ctrl.swap_ops ? op_b : op_a;
        add_y = ctrl.swap_ops ? op_a : op_b;
        if (ctrl.invert_y) begin
            add_y = ~add_y;
        end
        unique case (ctrl.cin_mode)
            CIN_ONE:   add_cin = 1'b1;
            CIN_CARRY: add_cin = cur_flags.c;
            default:   add_cin = 1'b0;
        endcase
    end

    dp_adder #(.WIDTH(WIDTH)) u_adder (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a      (op_a),
        .b      (op_b),
        .opcode (opcode),
        .y      (logic_res)
    );

    assign sel_res = ctrl.is_logic ? logic_res : add_sum;

    dp_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .value       (sel_res),
        .is_logic    (ctrl.is_logic),
        .set_flags   (set_flags),
        .shift_carry (shift_carry),
        .add_carry   (add_cout),
        .add_ovf     (add_ovf),
        .cur         (cur_flags),
        .nxt         (nxt_flags)
    );

    always_comb begin
        stage_d         = '0;
        stage_d.res     = sel_res;
        stage_d.we      = !ctrl.is_compare;
        stage_d.flags   = nxt_flags;
        stage_d.restore = dest_is_pc && set_flags;
        stage_d.illegal = ctrl.is_compare && !set_flags;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result       = stage_q.res;
    assign result_we    = stage_q.we;
    assign flags_out    = stage_q.flags;
    assign mode_restore = stage_q.restore;
    assign illegal_op   = stage_q.illegal;

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             shift_carry,
    input logic [3:0]       opcode,
    input logic             set_flags,
    input logic             dest_is_pc,
    input logic [3:0]       flags_in,
    input logic [WIDTH-1:0] result,
    input logic             result_we,
    input logic [3:0]       flags_out,
    input logic             mode_restore,
    input logic             illegal_op
);

    logic cmp_op;
    logic bitwise_op;
    assign cmp_op     = (opcode >= 4'h8) && (opcode <= 4'hB);
    assign bitwise_op = (opcode <= 4'h1) || (opcode == 4'h8) || (opcode == 4'h9) || (opcode >= 4'hC);

    // R4: compare opcodes never request a write
    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_op |=> !result_we);

    // R5: zero and negative flags track the registered result
    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flags_out[2] == (result == '0)) && (flags_out[3] == result[WIDTH-1]));

    // R6: bitwise opcodes take carry from the shifter and keep V
    assert_logic_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && bitwise_op) |=> (flags_out[1] == $past(shift_carry)) && (flags_out[0] == $past(flags_in[0])));

    // R8: no update request leaves flags untouched
    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> flags_out == $past(flags_in));

    // R9: compare without set-flags is flagged
    assert_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_op && !set_flags) |=> illegal_op);

    // R10: mode restore request follows its two conditions
    assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> mode_restore == $past(dest_is_pc && set_flags));

    // R11: outputs are zero the cycle after a reset cycle
    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (result == '0) && !result_we && (flags_out == '0) && !mode_restore && !illegal_op);

endmodule

bind dp_flag_alu dp_alu_checker #(.WIDTH(WIDTH)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_a         (op_a),
    .op_b         (op_b),
    .shift_carry  (shift_carry),
    .opcode       (opcode),
    .set_flags    (set_flags),
    .dest_is_pc   (dest_is_pc),
    .flags_in     (flags_in),
    .result       (result),
    .result_we    (result_we),
    .flags_out    (flags_out),
    .mode_restore (mode_restore),
    .illegal_op   (illegal_op)
);

// File: tb/dp_flag_alu_bench.sv
`timescale 1ns/1ps
module dp_flag_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        shift_carry = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic        dest_is_pc = 1'b0;
    logic [3:0]  flags_in = '0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_out;
    logic        mode_restore;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
        logic        restore;
        logic        illegal;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    dp_flag_alu u_dp_flag_alu (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_a         (op_a),
        .op_b         (op_b),
        .shift_carry  (shift_carry),
        .opcode       (opcode),
        .set_flags    (set_flags),
        .dest_is_pc   (dest_is_pc),
        .flags_in     (flags_in),
        .result       (result),
        .result_we    (result_we),
        .flags_out    (flags_out),
        .mode_restore (mode_restore),
        .illegal_op   (illegal_op)
    );

    // Reference model built from the requirements with wide integer math
    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic sc, input logic [3:0] op,
                                   input logic s, input logic pc,
                                   input logic [3:0] fin, input string tag);
        exp_t   e;
        longint ua = longint'({32'b0, a});
        longint ub = longint'({32'b0, b});
        longint sa = longint'(signed'(a));
        longint sb = longint'(signed'(b));
        longint ci = longint'(fin[1]);
        longint u = 0;
        longint sg = 0;
        bit     arith = 1;
        bit     c_new = 0;
        logic [31:0] r = '0;
        case (op)
            4'h0, 4'h8: begin r = a & b;  arith = 0; end
            4'h1, 4'h9: begin r = a ^ b;  arith = 0; end
            4'hC:       begin r = a | b;  arith = 0; end
            4'hD:       begin r = b;      arith = 0; end
            4'hE:       begin r = a & ~b; arith = 0; end
            4'hF:       begin r = ~b;     arith = 0; end
            4'h4, 4'hB: begin u = ua + ub;          sg = sa + sb;          c_new = (u > 64'hFFFFFFFF); end
            4'h5:       begin u = ua + ub + ci;     sg = sa + sb + ci;     c_new = (u > 64'hFFFFFFFF); end
            4'h2, 4'hA: begin u = ua - ub;          sg = sa - sb;          c_new = (u >= 0); end
            4'h3:       begin u = ub - ua;          sg = sb - sa;          c_new = (u >= 0); end
            4'h6:       begin u = ua - ub + ci - 1; sg = sa - sb + ci - 1; c_new = (u >= 0); end
            default:    begin u = ub - ua + ci - 1; sg = sb - sa + ci - 1; c_new = (u >= 0); end
        endcase
        if (arith) r = u[31:0];
        e.res     = r;
        e.we      = !(op >= 4'h8 && op <= 4'hB);
        e.fl      = fin;
        if (s) begin
            e.fl[3] = r[31];
            e.fl[2] = (r == 32'h0);
            e.fl[1] = arith ? c_new : sc;
            if (arith) e.fl[0] = (sg > 64'sd2147483647) || (sg < -64'sd2147483648);
        end
        e.restore = pc && s;
        e.illegal = !e.we && !s;
        e.tag     = tag;
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic s, input logic pc,
                         input logic [3:0] fin, input string tag);
        @(negedge clk);
        opcode = op; op_a = a; op_b = b; shift_carry = sc;
        set_flags = s; dest_is_pc = pc; flags_in = fin;
        sb_q.push_back(model(a, b, sc, op, s, pc, fin, tag));
    endtask

    // Monitor: an item queued before a rising edge is visible just after it
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            #1;
            checks++;
            if (result !== e.res || result_we !== e.we || flags_out !== e.fl ||
                mode_restore !== e.restore || illegal_op !== e.illegal) begin
                errors++;
                $display("FAIL %s: got res=%h we=%b fl=%b rst=%b ill=%b expected res=%h we=%b fl=%b rst=%b ill=%b",
                         e.tag, result, result_we, flags_out, mode_restore, illegal_op,
                         e.res, e.we, e.fl, e.restore, e.illegal);
            end
        end
    end

    initial begin
        #40000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // drive non-zero inputs during reset: outputs must stay zero (R11)
        op_a = 32'hFFFF_FFFF; op_b = 32'h1; opcode = 4'h4; set_flags = 1'b1;
        dest_is_pc = 1'b1; flags_in = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (result !== '0 || result_we !== 1'b0 || flags_out !== 4'h0 ||
            mode_restore !== 1'b0 || illegal_op !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: got res=%h we=%b fl=%b expected all zero",
                     result, result_we, flags_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 bitwise group; R6 carry from shifter, V kept
        drive(4'h0, 32'hF0F0_1234, 32'h0FF0_FF00, 1'b1, 1'b1, 1'b0, 4'b0001, "R1_and_R6");
        drive(4'h1, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, 1'b1, 1'b0, 4'b0011, "R1_eor_R6");
        drive(4'hC, 32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, 1'b0, 4'b0000, "R1_orr");
        drive(4'hD, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 4'b1001, "R1_mov_zero_R5");
        drive(4'hD, 32'hDEAD_BEEF, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 4'b1001, "R1_mov_ignores_a");
        drive(4'hF, 32'h5555_5555, 32'h0000_00FF, 1'b0, 1'b1, 1'b0, 4'b0110, "R1_mvn");
        drive(4'hE, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1'b0, 1'b1, 1'b0, 4'b0001, "R1_bic");
        drive(4'h8, 32'hF000_0000, 32'h0F00_0000, 1'b1, 1'b1, 1'b0, 4'b0001, "R4_tst_zero");
        drive(4'h9, 32'h8000_0001, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'b0010, "R4_teq_neg");
        // R2, R7 arithmetic with carry and overflow edges
        drive(4'h4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'b0000, "R2_add_ovf_R7");
        drive(4'h4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'b0000, "R2_add_carry_R7");
        drive(4'h2, 32'h0000_1000, 32'h0000_1000, 1'b0, 1'b1, 1'b0, 4'b0000, "R7_sub_equal_noborrow");
        drive(4'h2, 32'h0000_0001, 32'h0000_0002, 1'b1, 1'b1, 1'b0, 4'b0010, "R7_sub_borrow");
        drive(4'h2, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'b0000, "R7_sub_ovf");
        drive(4'h3, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b1, 1'b0, 4'b0000, "R2_rsb");
        // R3 carry-folding opcodes with carry set and clear
        drive(4'h5, 32'h0000_0010, 32'h0000_0020, 1'b0, 1'b1, 1'b0, 4'b0010, "R3_adc_c1");
        drive(4'h5, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 4'b0010, "R3_adc_wrap");
        drive(4'h6, 32'h0000_0010, 32'h0000_0010, 1'b0, 1'b1, 1'b0, 4'b0000, "R3_sbc_c0");
        drive(4'h6, 32'h0000_0010, 32'h0000_0010, 1'b0, 1'b1, 1'b0, 4'b0010, "R3_sbc_c1");
        drive(4'h7, 32'h0000_0003, 32'h0000_0009, 1'b0, 1'b1, 1'b0, 4'b0000, "R3_rsc_c0");
        // R4 compares with flags, R9 without
        drive(4'hA, 32'h0000_0003, 32'h0000_0007, 1'b0, 1'b1, 1'b0, 4'b0000, "R4_cmp");
        drive(4'hB, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'b0000, "R4_cmn");
        drive(4'hA, 32'h0000_0003, 32'h0000_0003, 1'b1, 1'b0, 1'b0, 4'b1010, "R9_cmp_noflags");
        drive(4'h9, 32'h0000_0003, 32'h0000_0003, 1'b1, 1'b0, 1'b1, 4'b0101, "R9_teq_noflags");
        // R8 flags untouched without request
        drive(4'h4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'b1001, "R8_add_noflags");
        drive(4'h0, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'b0000, "R8_and_noflags");
        // R10 mode restore
        drive(4'hD, 32'h0, 32'h0000_0100, 1'b0, 1'b1, 1'b1, 4'b0000, "R10_pc_flags");
        drive(4'hD, 32'h0, 32'h0000_0100, 1'b0, 1'b0, 1'b1, 4'b0000, "R10_pc_noflags");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule